// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Reader

This block moves outgoing frames from host memory to a byte stream. Software builds a ring of four-word descriptors in memory. It programs the address of the first descriptor, enables the engine and kicks it. The engine walks the ring and reads each descriptor's buffer through a 32-bit memory master port, one word at a time. It pushes the bytes into an internal FIFO, and the FIFO drains onto a valid/ready byte stream with a frame-end marker. Once a descriptor is finished, the engine hands it back by rewriting its status word with the ownership bit cleared.

Each descriptor holds four words: a status word, a control word, a buffer address and a next-descriptor address. The ownership bit is bit 31 of the status word. The control word carries:
- the byte length, in bits 13:0;
- the end-of-frame flag, in bit 30;
- a start-of-frame flag and two fixed bits, which software sets and the engine does not interpret.

When the engine reaches a descriptor it does not own, it stops and waits for the next kick. An optional whole-frame mode holds back the output until a complete frame sits in the FIFO.

Top module: `tdr_dma_reader`

## Requirements
- R1: After reset, `tx_valid` and `mem_req` are low and no descriptor is fetched.
- R2: A register write at offset 0x20 loads the descriptor pointer. At offset 0x14, bit 30 sets the enable, bit 1 sets whole-frame mode, and bit 31 is a one-shot kick. A write to any other offset changes nothing.
- R3: A descriptor is read at +0 (status), +4 (control), +8 (buffer) and +12 (next), in that order. When the status word has bit 31 clear, the engine goes idle and reads no further word until a kick.
- R4: A kick is honoured only when the same write also carries the enable bit. While the engine is idle, descriptors that software has marked owned are neither fetched nor sent.
- R5: A descriptor sends exactly control[13:0] bytes. The buffer address is taken as word aligned, and the bytes of each word go out little-endian: bits 7:0 first.
- R6: `tx_last` is high only on the final byte of a descriptor whose control bit 30 is set.
- R7: Write-back rewrites the status word with bit 31 cleared and every other bit kept. For an end-of-frame descriptor, this happens only after its final byte has been accepted downstream. For any other descriptor, it happens once its bytes are queued in the FIFO.
- R8: After write-back, the engine continues at the next-descriptor address, so a ring whose last entry points at the first entry wraps around.
- R9: In whole-frame mode, a frame that fits the FIFO is released only after its final byte is queued, so its bytes leave without gaps. Without whole-frame mode, bytes leave as soon as they are queued.
- R10: A kick that arrives while the engine is busy is remembered. After the engine next goes idle on an unowned descriptor, it polls that descriptor once more.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold.
- R12: A memory request holds its address and direction until `mem_ready`, and a write never carries status bit 31 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Request accepted; read data valid this cycle |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Stream sink ready |

## Verification
The bench sweeps every frame length from 1 to 12 in both output modes. It varies the memory stalls and the sink back-pressure, and it lets the ring wrap several times.

It targets these corner cases:
- **Byte lane selection in partial words.** Picking the wrong lane, or sending one byte too many or too few, shows up as a byte mismatch.
- **Frames split across two descriptors.** A `tx_last` on the first segment shows up in the frame-end check.
- **Whole-frame mode.** A release before the frame is complete shows up as a gap inside the frame.
- **Kicks.** A kick sent without enable, a write to a neighbouring offset, and an owned descriptor queued without a kick must all leave the output silent.
- **Kick during a busy fetch.** It must produce exactly one extra poll of the next, unowned descriptor. A design that drops the kick, or polls forever, shows up in the poll count.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

    localparam logic [7:0] OFS_CTRL = 8'h14;
    localparam logic [7:0] OFS_BASE = 8'h20;

    localparam int CTRL_KICK_BIT = 31;
    localparam int CTRL_EN_BIT   = 30;
    localparam int CTRL_SF_BIT   = 1;

    localparam int DESC_OWN_BIT  = 31;
    localparam int DESC_EOF_BIT  = 30;

    localparam int WORD_BYTES    = 4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STAT,
        S_CTRL,
        S_BUFA,
        S_NEXT,
        S_WORD,
        S_PUSH,
        S_DRAIN,
        S_WB
    } fetch_st_e;

    typedef struct packed {
        logic en;
        logic sf;
    } cfg_t;

endpackage

// File: rtl/tdr_regs.sv
module tdr_regs
    import tdr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [7:0]  addr,
    input  logic [31:0] wdata,
    output logic        enable,
    output logic        sf_mode,
    output logic        kick,
    output logic        base_load,
    output logic [31:0] base_val
);
    cfg_t cfg_d, cfg_q;
    logic ctrl_hit;

    assign ctrl_hit = wr && (addr == OFS_CTRL);

    always_comb begin
        cfg_d = cfg_q;
        if (ctrl_hit) begin
            cfg_d.en = wdata[CTRL_EN_BIT];
            cfg_d.sf = wdata[CTRL_SF_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign enable    = cfg_q.en;
    assign sf_mode   = cfg_q.sf;
    assign kick      = ctrl_hit && wdata[CTRL_KICK_BIT] && wdata[CTRL_EN_BIT];
    assign base_load = wr && (addr == OFS_BASE);
    assign base_val  = wdata;
endmodule

// File: rtl/tdr_fifo.sv
module tdr_fifo #(
    parameter int DEPTH  = 16,
    parameter int AW     = $clog2(DEPTH),
    parameter int FREE_W = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [7:0]        push_byte,
    input  logic              push_last,
    input  logic              sf_mode,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_last,
    output logic [FREE_W-1:0] free,
    output logic              empty
);
    typedef struct packed {
        logic [AW-1:0]     wp;
        logic [AW-1:0]     rp;
        logic [FREE_W-1:0] cnt;
        logic [FREE_W-1:0] frames;
    } fifo_regs_t;

    fifo_regs_t q, d;
    logic [8:0] store [DEPTH];
    logic pop, gate, head_last;

    assign empty     = (q.cnt == '0);
    assign free      = FREE_W'(DEPTH) - q.cnt;
    assign head_last = store[q.rp][8];
    // Whole-frame mode opens the gate when a frame end is held or no full word fits.
    assign gate      = !sf_mode || (q.frames != '0) || (free < FREE_W'(4));
    assign out_valid = !empty && gate;
    assign out_data  = store[q.rp][7:0];
    assign out_last  = head_last;
    assign pop       = out_valid && out_ready;

    always_comb begin
        d = q;
        if (push) d.wp = q.wp + AW'(1);
        if (pop)  d.rp = q.rp + AW'(1);
        d.cnt    = q.cnt + FREE_W'(push) - FREE_W'(pop);
        d.frames = q.frames + FREE_W'(push && push_last) - FREE_W'(pop && head_last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push) store[q.wp] <= {push_last, push_byte};
    end
endmodule

// File: rtl/tdr_fetch.sv
module tdr_fetch
    import tdr_pkg::*;
#(
    parameter int LEN_W  = 14,
    parameter int FREE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              kick,
    input  logic              base_load,
    input  logic [31:0]       base_val,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic              fifo_push,
    output logic [7:0]        fifo_byte,
    output logic              fifo_last,
    input  logic [FREE_W-1:0] fifo_free,
    input  logic              fifo_empty,
    output logic              idle
);
    typedef struct packed {
        fetch_st_e        st;
        logic             pend;
        logic [31:0]      ptr;
        logic [31:0]      stat;
        logic             eof;
        logic [LEN_W-1:0] rem;
        logic [31:0]      bufp;
        logic [31:0]      nxt;
        logic [31:0]      word;
        logic [1:0]       idx;
    } fetch_regs_t;

    fetch_regs_t q, d;
    logic last_byte;

    assign last_byte = (q.rem == LEN_W'(1));
    assign idle      = (q.st == S_IDLE);

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.ptr;
        mem_wdata = '0;
        fifo_push = 1'b0;
        fifo_byte = q.word[{q.idx, 3'b000} +: 8];
        fifo_last = 1'b0;
        if (kick) d.pend = 1'b1;

        case (q.st)
            S_IDLE: begin
                if (q.pend && enable) begin
                    d.pend = kick;
                    d.st   = S_STAT;
                end
            end
            S_STAT: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    d.stat = mem_rdata;
                    d.st   = mem_rdata[DESC_OWN_BIT] ? S_CTRL : S_IDLE;
                end
            end
            S_CTRL: begin
                mem_req  = 1'b1;
                mem_addr = q.ptr + 32'd4;
                if (mem_ready) begin
                    d.rem = mem_rdata[LEN_W-1:0];
                    d.eof = mem_rdata[DESC_EOF_BIT];
                    d.st  = S_BUFA;
                end
            end
            S_BUFA: begin
                mem_req  = 1'b1;
                mem_addr = q.ptr + 32'd8;
                if (mem_ready) begin
                    d.bufp = {mem_rdata[31:2], 2'b00};
                    d.st   = S_NEXT;
                end
            end
            S_NEXT: begin
                mem_req  = 1'b1;
                mem_addr = q.ptr + 32'd12;
                if (mem_ready) begin
                    d.nxt = mem_rdata;
                    if (q.rem != '0) d.st = S_WORD;
                    else             d.st = q.eof ? S_DRAIN : S_WB;
                end
            end
            S_WORD: begin
                if (fifo_free >= FREE_W'(WORD_BYTES)) begin
                    mem_req  = 1'b1;
                    mem_addr = q.bufp;
                    if (mem_ready) begin
                        d.word = mem_rdata;
                        d.idx  = '0;
                        d.bufp = q.bufp + 32'd4;
                        d.st   = S_PUSH;
                    end
                end
            end
            S_PUSH: begin
                fifo_push = 1'b1;
                fifo_last = q.eof && last_byte;
                d.rem     = q.rem - LEN_W'(1);
                d.idx     = q.idx + 2'd1;
                if (last_byte)          d.st = q.eof ? S_DRAIN : S_WB;
                else if (q.idx == 2'd3) d.st = S_WORD;
            end
            S_DRAIN: begin
                if (fifo_empty) d.st = S_WB;
            end
            S_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = q.stat & ~(32'd1 << DESC_OWN_BIT);
                if (mem_ready) begin
                    d.ptr = q.nxt;
                    d.st  = enable ? S_STAT : S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (base_load) d.ptr = base_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: S_IDLE, default: '0};
        else        q <= d;
    end
endmodule

// File: rtl/tdr_dma_reader.sv
module tdr_dma_reader
    import tdr_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int LEN_W      = 14
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ready,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready
);
    localparam int FIFO_AW = $clog2(FIFO_DEPTH);
    localparam int FREE_W  = FIFO_AW + 1;

    logic              cfg_en, cfg_sf, kick, base_load;
    logic [31:0]       base_val;
    logic              push, push_last;
    logic [7:0]        push_byte;
    logic [FREE_W-1:0] fifo_free;
    logic              fifo_empty, eng_idle;

    tdr_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .enable    (cfg_en),
        .sf_mode   (cfg_sf),
        .kick      (kick),
        .base_load (base_load),
        .base_val  (base_val)
    );

    tdr_fetch #(.LEN_W(LEN_W), .FREE_W(FREE_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (cfg_en),
        .kick       (kick),
        .base_load  (base_load),
        .base_val   (base_val),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .fifo_push  (push),
        .fifo_byte  (push_byte),
        .fifo_last  (push_last),
        .fifo_free  (fifo_free),
        .fifo_empty (fifo_empty),
        .idle       (eng_idle)
    );

    tdr_fifo #(.DEPTH(FIFO_DEPTH), .AW(FIFO_AW), .FREE_W(FREE_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_byte (push_byte),
        .push_last (push_last),
        .sf_mode   (cfg_sf),
        .out_ready (tx_ready),
        .out_valid (tx_valid),
        .out_data  (tx_data),
        .out_last  (tx_last),
        .free      (fifo_free),
        .empty     (fifo_empty)
    );
endmodule

// File: rtl/tdr_dma_reader_chk.sv
module tdr_dma_reader_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic        tx_last,
    input logic        mem_req,
    input logic        mem_ready,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        engine_idle,
    input logic        cfg_enable
);
    // R11
    stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R12 R7
    wb_owner_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[31]);

    // R4
    start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && $past(engine_idle)) |-> $past(cfg_enable));
endmodule

bind tdr_dma_reader tdr_dma_reader_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_data     (tx_data),
    .tx_last     (tx_last),
    .mem_req     (mem_req),
    .mem_ready   (mem_ready),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .engine_idle (eng_idle),
    .cfg_enable  (cfg_en)
);

// File: tb/tdr_dma_reader_tb.sv
`timescale 1ns/1ps
module tdr_dma_reader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;

    always #5 clk = ~clk;

    tdr_dma_reader u_dut (.*);

    int n_chk = 0, n_fail = 0;
    logic [31:0] mem [0:1023];
    logic [8:0]  exp_q [$];
    int  mem_stall = 0, stall_cnt = 0;
    int  rdy_mode = 0;
    logic [7:0] lfsr = 8'hA5;
    int  rx_cnt = 0;
    bit  in_frame = 0, gap_seen = 0;
    logic [31:0] watch_addr = 32'hFFFF_FFFF;
    int  watch_cnt = 0;
    bit  finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model: grants at the falling edge, consumed at the next rising edge
    always @(negedge clk) begin
        mem_ready = 1'b0;
        if (rst_n && mem_req) begin
            if (stall_cnt >= mem_stall) begin
                stall_cnt = 0;
                mem_ready = 1'b1;
                if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
                else begin
                    mem_rdata = mem[mem_addr[11:2]];
                    if (mem_addr == watch_addr) watch_cnt++;
                end
            end else stall_cnt++;
        end else stall_cnt = 0;
    end

    // stream sink
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tx_ready = rst_n && ((rdy_mode == 0) || lfsr[0]);
        if (in_frame && !tx_valid) gap_seen = 1;
        if (tx_valid && tx_ready) begin
            rx_cnt++;
            if (exp_q.size() == 0) chk(0, "R5 R6 unexpected byte", {23'd0, tx_last, tx_data}, 0);
            else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk({tx_last, tx_data} == e, "R5 R6 byte", {23'd0, tx_last, tx_data}, {23'd0, e});
            end
            in_frame = !tx_last;
        end
    end

    function automatic logic [7:0] byte_of(input int seed, input int i);
        return 8'(seed * 13 + i * 7 + 1);
    endfunction

    function automatic int st_word(input int slot);
        return (32'h100 + slot * 16) >> 2;
    endfunction

    task automatic reg_write(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic put_desc(input int slot, input int len, input bit first, input bit eof,
                            input int seed, output logic [31:0] exp_stat);
        int d, b;
        logic [31:0] st;
        d = st_word(slot);
        b = 32'h400 + slot * 64;
        st = 32'h8000_0000 | ((32'(seed) * 32'd37 + 32'd5) & 32'h00FF_FFFF);
        mem[d]     = st;
        mem[d + 1] = 32'(len) | (32'd1 << 24) | (32'(first) << 29) | (32'(eof) << 30) | (32'd1 << 31);
        mem[d + 2] = 32'(b);
        mem[d + 3] = 32'h100 + 32'(((slot + 1) % 4) * 16);
        for (int i = 0; i < len; i++) mem[(b + i) >> 2][8 * ((b + i) % 4) +: 8] = byte_of(seed, i);
        exp_stat = st & 32'h7FFF_FFFF;
    endtask

    task automatic push_exp(input int len, input bit eof, input int seed);
        for (int i = 0; i < len; i++) exp_q.push_back({eof && (i == len - 1), byte_of(seed, i)});
    endtask

    task automatic wait_status(input int slot, input logic [31:0] exp_stat, input bit eof);
        bit done = 0;
        for (int i = 0; i < 4000 && !done; i++) begin
            @(negedge clk); #1;
            if (!mem[st_word(slot)][31]) done = 1;
        end
        chk(mem[st_word(slot)] == exp_stat, "R7 status write-back", mem[st_word(slot)], exp_stat);
        if (eof) chk(exp_q.size() == 0, "R7 write-back after last byte", exp_q.size(), 0);
    endtask

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        logic [31:0] es, es2;
        int slot, cnt0;
        bit ct_gap;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle_wait(3);
        // R1
        chk(tx_valid == 1'b0, "R1 tx_valid after reset", tx_valid, 0);
        chk(mem_req == 1'b0, "R1 mem_req after reset", mem_req, 0);

        reg_write(8'h20, 32'h100);
        slot = 0;

        // R2 R4: kick without enable and a write to another offset start nothing
        put_desc(slot, 6, 1, 1, 99, es);
        reg_write(8'h14, 32'h8000_0000);
        reg_write(8'h18, 32'hC000_0002);
        idle_wait(120);
        chk(rx_cnt == 0, "R4 no output without enabled kick", rx_cnt, 0);
        chk(mem[st_word(slot)][31] == 1'b1, "R2 descriptor left owned", mem[st_word(slot)], 32'h8000_0000);
        push_exp(6, 1, 99);
        reg_write(8'h14, 32'hC000_0000);
        wait_status(slot, es, 1);
        slot = (slot + 1) % 4;
        idle_wait(30);

        // length sweep in both modes, with wrap around the ring
        ct_gap = 0;
        for (int sf = 0; sf < 2; sf++) begin
            for (int len = 1; len <= 12; len++) begin
                mem_stall = len % 3;
                rdy_mode  = len % 2;
                put_desc(slot, len, 1, 1, len + 20 * sf, es);
                push_exp(len, 1, len + 20 * sf);
                gap_seen = 0;
                reg_write(8'h14, 32'hC000_0000 | (32'(sf) << 1));
                wait_status(slot, es, 1);
                if (sf == 1) chk(gap_seen == 0, "R9 whole frame leaves contiguously", gap_seen, 0);
                else ct_gap |= gap_seen;
                slot = (slot + 1) % 4;
                idle_wait(30);
            end
            if (sf == 0) chk(ct_gap == 1, "R9 cut-through releases early", ct_gap, 1);
        end
        chk(mem[st_word((slot + 3) % 4)][31] == 1'b0, "R8 ring wrapped and last slot returned",
            mem[st_word((slot + 3) % 4)], 0);

        // two-segment frames
        for (int sf = 0; sf < 2; sf++) begin
            for (int k = 0; k < 3; k++) begin
                int a, b;
                a = (k == 0) ? 5 : (k == 1) ? 1 : 4;
                b = (k == 0) ? 3 : (k == 1) ? 7 : 8;
                mem_stall = k;
                rdy_mode  = k % 2;
                put_desc(slot, a, 1, 0, 50 + k, es);
                put_desc((slot + 1) % 4, b, 0, 1, 60 + k, es2);
                push_exp(a, 0, 50 + k);
                push_exp(b, 1, 60 + k);
                gap_seen = 0;
                reg_write(8'h14, 32'hC000_0000 | (32'(sf) << 1));
                wait_status(slot, es, 0);
                wait_status((slot + 1) % 4, es2, 1);
                if (sf == 1) chk(gap_seen == 0, "R9 split frame contiguous", gap_seen, 0);
                slot = (slot + 2) % 4;
                idle_wait(30);
            end
        end

        // R3: an owned descriptor queued without a kick stays put
        mem_stall = 1; rdy_mode = 0;
        cnt0 = rx_cnt;
        put_desc(slot, 7, 1, 1, 77, es);
        idle_wait(150);
        chk(rx_cnt == cnt0, "R3 idle until kick", rx_cnt, cnt0);
        push_exp(7, 1, 77);
        watch_addr = 32'h100 + 32'(((slot + 1) % 4) * 16);
        watch_cnt = 0;
        reg_write(8'h14, 32'hC000_0000);
        wait_status(slot, es, 1);
        idle_wait(100);
        chk(watch_cnt == 1, "R3 single poll of unowned descriptor", watch_cnt, 1);
        slot = (slot + 1) % 4;

        // R10: kick during busy fetch causes one more poll
        mem_stall = 4;
        put_desc(slot, 10, 1, 1, 88, es);
        push_exp(10, 1, 88);
        watch_addr = 32'h100 + 32'(((slot + 1) % 4) * 16);
        watch_cnt = 0;
        reg_write(8'h14, 32'hC000_0000);
        idle_wait(8);
        reg_write(8'h14, 32'hC000_0000);
        wait_status(slot, es, 1);
        idle_wait(100);
        chk(watch_cnt == 2, "R10 remembered kick re-polls", watch_cnt, 2);
        chk(exp_q.size() == 0, "R5 all bytes delivered", exp_q.size(), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule